// File: doc/BRIEF.md
# Grid-Tied Inverter Anti-Islanding Reference Injector

This block sits between the outer power loop and the current controller of a grid-tied inverter. On each sample strobe it takes the d-axis and q-axis current references and adds two small disturbance terms. The q-axis term is the frequency error multiplied by a gain and by the d-axis reference. The d-axis term is the sample-to-sample change in grid voltage magnitude, multiplied by the same gain. While the utility holds the grid stiff, both terms stay close to zero. Once the grid is lost, any drift in frequency or voltage feeds back through these terms and grows.

The block also watches the measured frequency. If it stays outside the allowed band for a programmable number of consecutive samples, a sticky trip flag is raised. While the trip flag is set, the disturbance terms are dropped, the base references pass through unchanged, and the output enable is withdrawn until software pulses the clear input. Frequency and gain are signed fixed-point values. Their number of fractional bits is a parameter, `FRAC`, with a default of 8.

Top module: `isle_ref_inject`

## Requirements
- R1: After reset, `id_out` and `iq_out` are 0, `island_trip` is 0 and `out_en` is 1.
- R2: The outputs `id_out` and `iq_out` change only on a clock edge where `smp_stb` is high. The new values appear right after that edge.
- R3: With df = freq − 60·2^FRAC, `iq_out` = sat(iq_base + sat(floor(sat(floor(gain·df / 2^FRAC)) · id_base / 2^FRAC))). Here sat clamps to the signed W-bit range (−32768..32767 at the defaults) and floor rounds toward minus infinity.
- R4: `id_out` = sat(id_base + sat(floor(gain·(vmag − vprev) / 2^FRAC))), where vprev is the `vmag` value taken at the previous strobe.
- R5: On the first strobe after reset there is no previous magnitude. The d-axis term is zero, so `id_out` = `id_base`.
- R6: Every product and every sum saturates to the signed W-bit range and never wraps.
- R7: A frequency counts as inside the window when FLO ≤ freq ≤ FHI, with FLO = floor(593·2^FRAC/10) (15180 at FRAC=8) and FHI = floor(605·2^FRAC/10) (15488). Both limits are inside the window. A sample inside the window resets the consecutive count.
- R8: `island_trip` rises right after the strobe on which the count of consecutive out-of-window samples reaches `trip_len`. A `trip_len` of 0 behaves as 1.
- R9: `island_trip` stays set until `trip_clr` is high on a clock edge. The clear clears it on that edge and takes priority over a trip on the same edge.
- R10: When a strobe leaves `island_trip` set, that strobe loads `id_out` = `id_base` and `iq_out` = `iq_base`. `out_en` is low whenever `island_trip` is high.
- R11: At exactly the nominal frequency, `iq_out` = `iq_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | Sample strobe, one cycle per control tick |
| freq_in | input | W | Measured grid frequency, signed, FRAC fractional bits |
| vmag_in | input | W | Grid voltage magnitude, signed |
| id_base | input | W | Base d-axis current reference |
| iq_base | input | W | Base q-axis current reference |
| gain_k | input | W | Feedback gain, signed, FRAC fractional bits |
| trip_len | input | CW | Consecutive out-of-window samples needed to trip |
| trip_clr | input | 1 | Clears the trip flag |
| id_out | output | W | Perturbed d-axis reference |
| iq_out | output | W | Perturbed q-axis reference |
| out_en | output | 1 | Output enable, low while tripped |
| island_trip | output | 1 | Latched islanding flag |

## Verification
Suppose the stored previous magnitude is wrong, for example it is not loaded or not seeded on the first sample. The error then shows up in `id_out` right after the very next strobe, as a step that the inputs do not explain. A miscounting consecutive-sample counter makes `island_trip` rise one strobe too early or too late. This is visible at the strobe where the count should reach `trip_len`, and also in a run that is broken by an in-window sample. A stuck trip register shows up as perturbed outputs, or as `out_en` staying high, on the first strobe after the trip. Window-limit errors show up only when the frequency sits exactly on a band edge, so the tests place samples at those edges.

// File: rtl/isle_pkg.sv
package isle_pkg;
  // Derived frequency limits, scaled by the fixed-point fraction.
  function automatic int f_nominal(input int frac);
    return 60 * (1 << frac);
  endfunction

  function automatic int f_low(input int frac);
    return (593 * (1 << frac)) / 10;
  endfunction

  function automatic int f_high(input int frac);
    return (605 * (1 << frac)) / 10;
  endfunction
endpackage

// File: rtl/isle_mul_sat.sv
module isle_mul_sat #(
  parameter int AW = 16,
  parameter int BW = 16,
  parameter int OW = 16,
  parameter int SH = 8
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  output logic signed [OW-1:0] y
);
  localparam int PW = AW + BW;
  localparam logic signed [PW-1:0] MAXV = signed'({{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}});
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shd;

  assign prod = PW'(a) * PW'(b);
  assign shd  = prod >>> SH;

  always_comb begin
    if (shd > MAXV)      y = MAXV[OW-1:0];
    else if (shd < MINV) y = MINV[OW-1:0];
    else                 y = shd[OW-1:0];
  end
endmodule

// File: rtl/isle_vstep.sv
module isle_vstep #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic signed [W-1:0] vmag,
  output logic signed [W:0]   dv
);
  logic signed [W-1:0] vprev_q, vprev_d;
  logic                seen_q, seen_d;

  always_comb begin
    vprev_d = vprev_q;
    seen_d  = seen_q;
    if (stb) begin
      vprev_d = vmag;
      seen_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vprev_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      vprev_q <= vprev_d;
      seen_q  <= seen_d;
    end
  end

  assign dv = seen_q ? ({vmag[W-1], vmag} - {vprev_q[W-1], vprev_q}) : '0;
endmodule

// File: rtl/isle_freq_watch.sv
module isle_freq_watch #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int CW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic signed [W-1:0] freq,
  input  logic [CW-1:0]       lim_len,
  input  logic                clr,
  output logic                trip_q,
  output logic                trip_nx
);
  import isle_pkg::*;
  localparam logic signed [W-1:0] FLO = W'(f_low(FRAC));
  localparam logic signed [W-1:0] FHI = W'(f_high(FRAC));

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic [CW:0]   need;
  logic          outside;

  assign outside = (freq < FLO) || (freq > FHI);
  assign need    = (lim_len == '0) ? (CW+1)'(1) : {1'b0, lim_len};
  assign cnt_inc = (&cnt_q) ? {1'b0, cnt_q} : ({1'b0, cnt_q} + 1'b1);

  always_comb begin
    cnt_d   = cnt_q;
    trip_nx = trip_q;
    if (clr) begin
      cnt_d   = '0;
      trip_nx = 1'b0;
    end else if (stb) begin
      if (outside) begin
        cnt_d = cnt_inc[CW-1:0];
        if (cnt_inc >= need) trip_nx = 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_nx;
    end
  end
endmodule

// File: rtl/isle_ref_inject.sv
module isle_ref_inject #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int CW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_stb,
  input  logic signed [W-1:0] freq_in,
  input  logic signed [W-1:0] vmag_in,
  input  logic signed [W-1:0] id_base,
  input  logic signed [W-1:0] iq_base,
  input  logic signed [W-1:0] gain_k,
  input  logic [CW-1:0]       trip_len,
  input  logic                trip_clr,
  output logic signed [W-1:0] id_out,
  output logic signed [W-1:0] iq_out,
  output logic                out_en,
  output logic                island_trip
);
  import isle_pkg::*;
  localparam logic signed [W:0]   F0V  = (W+1)'(f_nominal(FRAC));
  localparam logic signed [W-1:0] SMAX = signed'({1'b0, {(W-1){1'b1}}});
  localparam logic signed [W-1:0] SMIN = ~SMAX;
  localparam int NAX = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic signed [W:0]   df;
  logic signed [W:0]   dv;
  logic signed [W-1:0] kf;
  logic signed [W-1:0] q_term, d_term;
  logic                trip_q, trip_nx;

  assign df = {freq_in[W-1], freq_in} - F0V;

  isle_vstep #(.W(W)) u_vstep (
    .clk(clk), .rst_n(rst_ni), .stb(smp_stb), .vmag(vmag_in), .dv(dv)
  );

  isle_freq_watch #(.W(W), .FRAC(FRAC), .CW(CW)) u_watch (
    .clk(clk), .rst_n(rst_ni), .stb(smp_stb), .freq(freq_in),
    .lim_len(trip_len), .clr(trip_clr), .trip_q(trip_q), .trip_nx(trip_nx)
  );

  isle_mul_sat #(.AW(W), .BW(W+1), .OW(W), .SH(FRAC)) u_kf (
    .a(gain_k), .b(df), .y(kf)
  );
  isle_mul_sat #(.AW(W), .BW(W), .OW(W), .SH(FRAC)) u_kfi (
    .a(kf), .b(id_base), .y(q_term)
  );
  isle_mul_sat #(.AW(W), .BW(W+1), .OW(W), .SH(FRAC)) u_kv (
    .a(gain_k), .b(dv), .y(d_term)
  );

  logic signed [W-1:0] base_v [NAX];
  logic signed [W-1:0] term_v [NAX];
  logic signed [W-1:0] sum_v  [NAX];
  logic signed [W-1:0] ref_q  [NAX];
  logic signed [W-1:0] ref_d  [NAX];

  assign base_v[0] = id_base;
  assign base_v[1] = iq_base;
  assign term_v[0] = trip_nx ? '0 : d_term;
  assign term_v[1] = trip_nx ? '0 : q_term;

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    logic signed [W:0] wide;
    assign wide = {base_v[g][W-1], base_v[g]} + {term_v[g][W-1], term_v[g]};
    assign sum_v[g] = (wide[W] != wide[W-1]) ? (wide[W] ? SMIN : SMAX) : wide[W-1:0];

    always_comb begin
      ref_d[g] = ref_q[g];
      if (smp_stb) ref_d[g] = sum_v[g];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) ref_q[g] <= '0;
      else         ref_q[g] <= ref_d[g];
    end
  end

  assign id_out      = ref_q[0];
  assign iq_out      = ref_q[1];
  assign island_trip = trip_q;
  assign out_en      = ~trip_q;
endmodule

// File: rtl/isle_ref_inject_chk.sv
module isle_ref_inject_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_stb,
  input logic                trip_clr,
  input logic signed [W-1:0] id_base,
  input logic signed [W-1:0] iq_base,
  input logic signed [W-1:0] id_out,
  input logic signed [W-1:0] iq_out,
  input logic                out_en,
  input logic                island_trip
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(id_out) && $stable(iq_out)));

  assert_rise_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(island_trip) |-> $past(smp_stb));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (island_trip && !trip_clr) |=> island_trip);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trip_clr |=> !island_trip);

  assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (island_trip && $past(smp_stb) && !$past(trip_clr)) |->
      (id_out == $past(id_base) && iq_out == $past(iq_base)));

  assert_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    island_trip |-> !out_en);
endmodule

bind isle_ref_inject isle_ref_inject_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .trip_clr(trip_clr),
  .id_base(id_base), .iq_base(iq_base), .id_out(id_out), .iq_out(iq_out),
  .out_en(out_en), .island_trip(island_trip)
);

// File: tb/sim_isle_ref_inject.sv
`timescale 1ns/1ps
module sim_isle_ref_inject;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [15:0] freq_in = 16'sd15360;
  logic signed [15:0] vmag_in = '0;
  logic signed [15:0] id_base = '0;
  logic signed [15:0] iq_base = '0;
  logic signed [15:0] gain_k  = '0;
  logic [7:0]         trip_len = 8'd1;
  logic               trip_clr = 1'b0;
  logic signed [15:0] id_out, iq_out;
  logic               out_en, island_trip;

  int n_chk = 0;
  int n_err = 0;
  longint vp = 0;
  bit     have_vp = 0;
  bit     done = 0;

  always #2.5 clk = ~clk;

  isle_ref_inject u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .freq_in(freq_in),
    .vmag_in(vmag_in), .id_base(id_base), .iq_base(iq_base), .gain_k(gain_k),
    .trip_len(trip_len), .trip_clr(trip_clr), .id_out(id_out), .iq_out(iq_out),
    .out_en(out_en), .island_trip(island_trip)
  );

  function automatic longint sat(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint shr(input longint v);
    return v >>> 8;
  endfunction

  function automatic longint exp_q();
    longint kf;
    kf = sat(shr(longint'(gain_k) * (longint'(freq_in) - 15360)));
    return sat(longint'(iq_base) + sat(shr(kf * longint'(id_base))));
  endfunction

  function automatic longint exp_d();
    if (!have_vp) return longint'(id_base);
    return sat(longint'(id_base) + sat(shr(longint'(gain_k) * (longint'(vmag_in) - vp))));
  endfunction

  task automatic chk(input string tag, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // One strobe; the outputs are sampled at the falling edge after it.
  task automatic tick();
    @(negedge clk) smp_stb = 1'b1;
    @(negedge clk) smp_stb = 1'b0;
    vp = longint'(vmag_in);
    have_vp = 1;
  endtask

  task automatic tick_chk(input string tag);
    longint ed, eq;
    @(negedge clk);
    ed = exp_d(); eq = exp_q();
    tick();
    chk({tag, " id"}, id_out, ed);
    chk({tag, " iq"}, iq_out, eq);
  endtask

  task automatic t_reset_R1();
    chk("R1 id_out", id_out, 0);
    chk("R1 iq_out", iq_out, 0);
    chk("R1 trip", island_trip, 0);
    chk("R1 out_en", out_en, 1);
  endtask

  task automatic t_first_R5_R11();
    freq_in = 16'sd15360; vmag_in = 16'sd1000; id_base = 16'sd500;
    iq_base = -16'sd200; gain_k = 16'sd256;
    tick();
    chk("R5 first id", id_out, 500);
    chk("R11 nominal iq", iq_out, -200);
  endtask

  task automatic t_hold_R2();
    @(negedge clk);
    id_base = 16'sd1234; iq_base = 16'sd4321; freq_in = 16'sd15400; vmag_in = 16'sd3000;
    repeat (4) @(negedge clk);
    chk("R2 hold id", id_out, 500);
    chk("R2 hold iq", iq_out, -200);
    freq_in = 16'sd15360; vmag_in = 16'sd1000;
  endtask

  task automatic t_dstep_R4();
    gain_k = 16'sd512; id_base = 16'sd300; vmag_in = 16'sd1100;
    tick();
    chk("R4 up step", id_out, 500);
    vmag_in = 16'sd1037;
    tick_chk("R4 down step");
    vmag_in = 16'sd1037;
    tick();
    chk("R4 no step", id_out, 300);
  endtask

  task automatic t_q_R3();
    gain_k = 16'sd256; id_base = 16'sd1000; iq_base = 16'sd100; freq_in = 16'sd15424;
    tick();
    chk("R3 pos df", iq_out, 350);
    freq_in = 16'sd15232;
    tick();
    chk("R3 neg df", iq_out, -400);
    gain_k = 16'sd77; id_base = -16'sd913; freq_in = 16'sd15301;
    tick_chk("R3 odd values");
  endtask

  task automatic t_sat_R6();
    gain_k = 16'sd32767; id_base = 16'sd30000; iq_base = 16'sd30000;
    freq_in = 16'sd15480; vmag_in = 16'sd20000;
    tick();
    chk("R6 id high", id_out, 32767);
    chk("R6 iq high", iq_out, 32767);
    id_base = -16'sd30000; iq_base = -16'sd100; vmag_in = -16'sd20000; freq_in = 16'sd15480;
    tick();
    chk("R6 id low", id_out, -32768);
    chk("R6 iq low", iq_out, -32768);
    gain_k = 16'sd256; vmag_in = -16'sd20000; id_base = 16'sd100; iq_base = 16'sd0;
    freq_in = 16'sd15360;
    tick();
  endtask

  task automatic t_window_R7_R8();
    trip_len = 8'd1;
    freq_in = 16'sd15180;
    tick();
    chk("R7 low edge", island_trip, 0);
    freq_in = 16'sd15488;
    tick();
    chk("R7 high edge", island_trip, 0);
    freq_in = 16'sd15489;
    tick();
    chk("R8 len1 trip", island_trip, 1);
    @(negedge clk) trip_clr = 1'b1;
    @(negedge clk) trip_clr = 1'b0;
    chk("R9 clear", island_trip, 0);
    chk("R9 enable back", out_en, 1);
    trip_len = 8'd0;
    freq_in = 16'sd15179;
    tick();
    chk("R8 len0 trip", island_trip, 1);
    @(negedge clk) trip_clr = 1'b1;
    @(negedge clk) trip_clr = 1'b0;
  endtask

  task automatic t_run_R8_R10();
    trip_len = 8'd3; gain_k = 16'sd256; id_base = 16'sd800; iq_base = 16'sd50;
    freq_in = 16'sd15000; tick();
    tick();
    chk("R8 two out", island_trip, 0);
    freq_in = 16'sd15360; tick();
    chk("R7 reset count", island_trip, 0);
    freq_in = 16'sd15600; tick(); tick();
    chk("R8 run restarted", island_trip, 0);
    vmag_in = 16'sd5000; tick();
    chk("R8 third out", island_trip, 1);
    chk("R10 id base", id_out, 800);
    chk("R10 iq base", iq_out, 50);
    chk("R10 out_en low", out_en, 0);
  endtask

  task automatic t_sticky_R9();
    freq_in = 16'sd15360; vmag_in = 16'sd6000; tick(); tick();
    chk("R9 sticky", island_trip, 1);
    chk("R10 still base", id_out, 800);
    // clear wins over a trip on the same edge
    trip_len = 8'd1; freq_in = 16'sd15000;
    @(negedge clk) begin trip_clr = 1'b1; smp_stb = 1'b1; end
    @(negedge clk) begin trip_clr = 1'b0; smp_stb = 1'b0; end
    vp = longint'(vmag_in);
    chk("R9 clear priority", island_trip, 0);
    freq_in = 16'sd15360;
    tick();
    chk("R9 perturb resumes", id_out, 800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_R1();
    t_first_R5_R11();
    t_hold_R2();
    t_dstep_R4();
    t_q_R3();
    t_sat_R6();
    t_window_R7_R8();
    t_run_R8_R10();
    t_sticky_R9();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule